// File: doc/BRIEF.md
# SCL timing generator

This block produces the serial clock for an I2C master. Two programmable period counts set the clock. One count sets how long SCL is held low and the other sets how long it stays high. Both are counted in ticks of a prescaled clock. The block only ever pulls SCL low or releases it. It watches the returned SCL level through a synchronizer, so a slow rising edge or a slave that stretches the clock lengthens the bit rather than shortening the high time.

The byte engine that sits beside it gets a set of single-cycle strobes. One marks the START edge. One falls in the middle of every low phase, where SDA may change. One marks the first counted cycle of every high phase, where SDA is sampled. One marks the end of the STOP setup time. The START hold time and the STOP setup time both reuse the high count. The low count sets the low phase of the STOP bit and the bus-free gap that follows STOP. The engine holds `xferOn` high for as long as clock pulses are wanted. The generator finishes with a STOP once that request is gone at the end of a high phase.

Top module: `scl_clock_gen`

## Requirements
- R1: Each low phase pulls SCL low for exactly L x D clock cycles. L is the effective low count and D is the effective divider. Counting starts in the first cycle of the pull-low, so the fall time is inside the programmed value.
- R2: Counting of a high phase starts only when the SCL input, after a two-stage synchronizer, is seen high. The input is therefore high for exactly H x D + 2 cycles before the next pull-low, where H is the effective high count. This holds whatever the rise delay or the clock stretching.
- R3: Each effective count is 9 bits wide. `countMsbs[1]` is bit 8 of the low count and `countMsbs[0]` is bit 8 of the high count. Neither bit has any effect on the other count.
- R4: A count whose 9-bit value is zero acts as one tick.
- R5: The prescaler gives one count tick every `clkDiv` clock cycles, and a value of 0 acts as 1. The prescaler restarts at the start of every phase.
- R6: `midLowStb` pulses exactly once in each low phase, and only while SCL is pulled low. It falls in cycle ((L-1) div 2 + 1) x D - 1, counting the first low cycle as 0.
- R7: `sampleStb` pulses once per data-bit high phase. It comes in the first counted high cycle, which is the third consecutive cycle with the SCL input high.
- R8: From idle, with `enable` and `xferOn` high and SCL seen high, `startStb` pulses. SCL then stays released for H x D cycles, counting the strobe cycle, before the first pull-low.
- R9: If `xferOn` is low when a high phase ends, one more low phase of L x D cycles follows. A high phase of H x D cycles then follows, and `stopStb` marks its last cycle. After that, `busy` stays high for L x D more cycles and then falls with SCL released.
- R10: While `enable` is low, the generator releases SCL and reports not busy from the next cycle on, and no transfer starts.
- R11: During reset SCL is released, `busy` is low and no strobe is active.
- R12: The standard-rate programming is a 25 MHz count clock with low 125 and high 108, giving 1250 and 1080 cycles at D = 10. The fast-rate programming is low 40 and high 23, giving 400 and 230 cycles. Both produce those phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable; low forces idle with SCL released |
| xferOn | input | 1 | Byte engine requests clock pulses; dropping it ends with STOP |
| clkDiv | input | 8 | Clocks per count tick (0 acts as 1) |
| lowCount | input | 8 | Low-phase count, bits 7..0 |
| highCount | input | 8 | High-phase count, bits 7..0 |
| countMsbs | input | 2 | Bit 1: low count bit 8; bit 0: high count bit 8 |
| sclIn | input | 1 | Level of the SCL line as seen at the pad |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| busy | output | 1 | A START..bus-free sequence is in progress |
| startStb | output | 1 | Engine drives SDA low for START |
| midLowStb | output | 1 | Middle of a low phase: SDA may change |
| sampleStb | output | 1 | First counted high cycle: SDA may be sampled |
| stopStb | output | 1 | End of STOP setup: engine releases SDA |

## Verification
The bench stretches the clock and slows the rising edge. A design that started the high count at release instead of at the synchronized high level would then show a shortened high time. A 9-bit count of zero is checked against one tick, and a divider of zero against one cycle per tick. A design that decremented past zero would instead stall for hundreds of cycles. The ninth bits are set one at a time, so swapped bit positions show as the wrong phase stretching by 256 ticks. Dropping `enable` in the middle of a low phase must release SCL on the next cycle. A design that finished the phase first would keep the line low.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Sequencer phases of the clock generator
  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_START_HOLD = 4'd1,
    ST_LOW        = 4'd2,
    ST_RISE       = 4'd3,
    ST_HIGH       = 4'd4,
    ST_STOP_LOW   = 4'd5,
    ST_STOP_RISE  = 4'd6,
    ST_STOP_HIGH  = 4'd7,
    ST_BUS_FREE   = 4'd8
  } sclPhase_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic restart;   // a new phase begins next cycle: clear prescaler and phase counter
    logic countOn;   // the current phase is a timed one
  } dpCtl_t;

  // Datapath -> control status
  typedef struct packed {
    logic lowDone;   // last tick of a low-count window
    logic highDone;  // last tick of a high-count window
    logic lowHalf;   // middle tick of a low-count window
    logic sclHigh;   // synchronized SCL level
  } dpStat_t;

endpackage

// File: rtl/scl_gen_datapath.sv
module scl_gen_datapath
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic [1:0]       countMsbs,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             sclIn,
  input  dpCtl_t           ctl,
  output dpStat_t          stat
);

  localparam int PH_W = CNT_W + 1;

  // 9-bit effective count; zero acts as a single tick
  function automatic logic [PH_W-1:0] widen(input logic msb, input logic [CNT_W-1:0] base);
    logic [PH_W-1:0] v;
    v = {msb, base};
    return (v == '0) ? PH_W'(1) : v;
  endfunction

  // ---------------- SCL input synchronizer ----------------
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], sclIn};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= sclIn;
      end
    end
  endgenerate

  // ---------------- prescaler ----------------
  logic [DIV_W-1:0] divEff;
  logic [DIV_W-1:0] preCnt;
  logic             tick;

  assign divEff = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
  assign tick   = (preCnt == divEff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)                    preCnt <= '0;
    else if (ctl.restart || tick) preCnt <= '0;
    else                          preCnt <= preCnt + DIV_W'(1);
  end

  // ---------------- phase counter ----------------
  logic [PH_W-1:0] phCnt;
  logic [PH_W-1:0] effLow, effHigh, lastLow, lastHigh, halfLow;

  assign effLow   = widen(countMsbs[1], lowCount);
  assign effHigh  = widen(countMsbs[0], highCount);
  assign lastLow  = effLow - PH_W'(1);
  assign lastHigh = effHigh - PH_W'(1);
  assign halfLow  = lastLow >> 1;

  always_ff @(posedge clk) begin
    if (!rstN)                    phCnt <= '0;
    else if (ctl.restart)         phCnt <= '0;
    else if (ctl.countOn && tick) phCnt <= phCnt + PH_W'(1);
  end

  always_comb begin
    stat.lowDone  = tick && (phCnt == lastLow);
    stat.highDone = tick && (phCnt == lastHigh);
    stat.lowHalf  = tick && (phCnt == halfLow);
    stat.sclHigh  = syncChain[SYNC_STAGES-1];
  end

endmodule

// File: rtl/scl_gen_control.sv
module scl_gen_control
  import scl_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    xferOn,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    sclDriveLow,
  output logic    busy,
  output logic    startStb,
  output logic    midLowStb,
  output logic    sampleStb,
  output logic    stopStb
);

  sclPhase_e state, nextState;
  logic      freshPhase;  // first cycle of the current phase

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:       if (xferOn && stat.sclHigh) nextState = ST_START_HOLD;
      ST_START_HOLD: if (stat.highDone)          nextState = ST_LOW;
      ST_LOW:        if (stat.lowDone)           nextState = ST_RISE;
      ST_RISE:       if (stat.sclHigh)           nextState = ST_HIGH;
      ST_HIGH:       if (stat.highDone)          nextState = xferOn ? ST_LOW : ST_STOP_LOW;
      ST_STOP_LOW:   if (stat.lowDone)           nextState = ST_STOP_RISE;
      ST_STOP_RISE:  if (stat.sclHigh)           nextState = ST_STOP_HIGH;
      ST_STOP_HIGH:  if (stat.highDone)          nextState = ST_BUS_FREE;
      ST_BUS_FREE:   if (stat.lowDone)           nextState = ST_IDLE;
      default:                                   nextState = ST_IDLE;
    endcase
    if (!enable) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      freshPhase <= 1'b0;
    end else begin
      state      <= nextState;
      freshPhase <= ctl.restart;
    end
  end

  always_comb begin
    ctl.restart = (nextState != state);
    ctl.countOn = (state != ST_IDLE) && (state != ST_RISE) && (state != ST_STOP_RISE);
  end

  always_comb begin
    sclDriveLow = (state == ST_LOW) || (state == ST_STOP_LOW);
    busy        = (state != ST_IDLE);
    startStb    = (state == ST_START_HOLD) && freshPhase;
    sampleStb   = (state == ST_HIGH) && freshPhase;
    midLowStb   = sclDriveLow && stat.lowHalf;
    stopStb     = (state == ST_STOP_HIGH) && stat.highDone;
  end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             xferOn,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic [1:0]       countMsbs,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             busy,
  output logic             startStb,
  output logic             midLowStb,
  output logic             sampleStb,
  output logic             stopStb
);

  dpCtl_t  ctl;
  dpStat_t stat;

  scl_gen_datapath #(
    .CNT_W      (CNT_W),
    .DIV_W      (DIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lowCount (lowCount),
    .highCount(highCount),
    .countMsbs(countMsbs),
    .clkDiv   (clkDiv),
    .sclIn    (sclIn),
    .ctl      (ctl),
    .stat     (stat)
  );

  scl_gen_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .xferOn     (xferOn),
    .stat       (stat),
    .ctl        (ctl),
    .sclDriveLow(sclDriveLow),
    .busy       (busy),
    .startStb   (startStb),
    .midLowStb  (midLowStb),
    .sampleStb  (sampleStb),
    .stopStb    (stopStb)
  );

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclDriveLow,
  input logic busy,
  input logic startStb,
  input logic midLowStb,
  input logic sampleStb,
  input logic stopStb
);

  // R10
  disable_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !busy));

  // R6
  mid_in_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    midLowStb |-> sclDriveLow);

  // R7
  sample_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (!sclDriveLow && busy));

  // R8
  start_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |-> ($past(busy) == 1'b0));

  // R9
  stop_then_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |=> (busy && !sclDriveLow && !stopStb));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startStb, midLowStb, sampleStb, stopStb}));

endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .sclDriveLow(sclDriveLow),
  .busy       (busy),
  .startStb   (startStb),
  .midLowStb  (midLowStb),
  .sampleStb  (sampleStb),
  .stopStb    (stopStb)
);

// File: tb/sim_scl_clock_gen.sv
module sim_scl_clock_gen;

  localparam int K_GAP = 0, K_LOW = 1, K_MID = 2, K_SAMPLE = 3, K_HIGH = 4, K_STOPH = 5, K_FREE = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       xferOn = 1'b0;
  logic [7:0] clkDiv = 8'd1;
  logic [7:0] lowCount = 8'd4;
  logic [7:0] highCount = 8'd4;
  logic [1:0] countMsbs = 2'b00;
  logic       sclIn = 1'b0;
  logic       sclDriveLow, busy, startStb, midLowStb, sampleStb, stopStb;

  int nChecks = 0;
  int nFails = 0;
  bit monOn = 1'b1;
  int riseDly = 2;
  int stretchDly = 0;
  int lineCnt = 0;

  int    expKind[$];
  int    expVal[$];
  string expReq[$];

  always #2 clk = ~clk;  // 250 MHz

  scl_clock_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .xferOn(xferOn), .clkDiv(clkDiv),
    .lowCount(lowCount), .highCount(highCount), .countMsbs(countMsbs), .sclIn(sclIn),
    .sclDriveLow(sclDriveLow), .busy(busy), .startStb(startStb), .midLowStb(midLowStb),
    .sampleStb(sampleStb), .stopStb(stopStb)
  );

  // Bus line model: open-drain with rise delay and slave stretching, updated on falling edges
  always @(negedge clk) begin
    if (sclDriveLow) begin
      sclIn   <= 1'b0;
      lineCnt <= 0;
    end else if (lineCnt < riseDly + stretchDly) begin
      lineCnt <= lineCnt + 1;
    end else begin
      sclIn <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int val, input string req);
    expKind.push_back(kind);
    expVal.push_back(val);
    expReq.push_back(req);
  endtask

  task automatic report(input int kind, input int val);
    if (expKind.size() == 0) begin
      check(1'b0, "R9", $sformatf("unexpected event kind %0d", kind), val, -1);
    end else begin
      int k;
      int v;
      string r;
      k = expKind.pop_front();
      v = expVal.pop_front();
      r = expReq.pop_front();
      check(k == kind && v == val, r, $sformatf("event kind %0d (expected kind %0d)", kind, k), val, v);
    end
  endtask

  // Monitor: measures phases at the ports and compares with the scoreboard
  int lowRun = 0, highRun = 0, gapRun = 0, freeRun = 0;
  bit prevD = 1'b0, afterLow = 1'b0, gapOn = 1'b0, freeOn = 1'b0;

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (monOn) begin
        if (freeOn) begin
          if (busy) freeRun++;
          else begin report(K_FREE, freeRun); freeOn = 1'b0; end
        end
        if (gapOn) begin
          if (sclDriveLow) begin report(K_GAP, gapRun); gapOn = 1'b0; end
          else gapRun++;
        end
        if (startStb) begin gapOn = 1'b1; gapRun = 1; end
        if (sclDriveLow) begin
          if (!prevD && afterLow) report(K_HIGH, highRun);
          if (!prevD) begin lowRun = 0; highRun = 0; afterLow = 1'b0; end
          lowRun++;
          if (midLowStb) report(K_MID, lowRun - 1);
        end else begin
          if (prevD) begin report(K_LOW, lowRun); afterLow = 1'b1; highRun = 0; end
          if (afterLow && sclIn) highRun++;
          if (sampleStb) report(K_SAMPLE, highRun);
          if (stopStb) begin
            report(K_STOPH, highRun);
            afterLow = 1'b0;
            freeOn = 1'b1;
            freeRun = 0;
          end
        end
        prevD = sclDriveLow;
      end
    end
  end

  function automatic int effv(input bit msb, input int c);
    int v;
    v = (msb ? 256 : 0) + c;
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int ticksFor(input int khz, input int tenthsUs);
    return (khz * tenthsUs + 5000) / 10000;
  endfunction

  // Driver: programs one transfer, pushes its expected events, runs it
  task automatic runXfer(input int d, input int lc, input int hc, input bit [1:0] msbs,
                         input int nBits, input int rd, input int st, input string ctx);
    int dv, effL, el, eh, m, n;
    dv   = (d == 0) ? 1 : d;
    effL = effv(msbs[1], lc);
    el   = effL * dv;
    eh   = effv(msbs[0], hc) * dv;
    m    = (((effL - 1) >> 1) + 1) * dv - 1;
    clkDiv     = 8'(d);
    lowCount   = 8'(lc);
    highCount  = 8'(hc);
    countMsbs  = msbs;
    riseDly    = rd;
    stretchDly = st;
    push(K_GAP, eh, {ctx, " R8 start hold"});
    for (int i = 0; i < nBits; i++) begin
      push(K_MID, m, {ctx, " R6 mid-low offset"});
      push(K_LOW, el, {ctx, " R1 low length"});
      push(K_SAMPLE, 3, {ctx, " R7 sample position"});
      push(K_HIGH, eh + 2, {ctx, " R2 high length"});
    end
    push(K_MID, m, {ctx, " R6 stop mid-low offset"});
    push(K_LOW, el, {ctx, " R9 stop low length"});
    push(K_STOPH, eh + 2, {ctx, " R9 stop setup"});
    push(K_FREE, el, {ctx, " R9 bus free"});
    xferOn = 1'b1;
    n = 0;
    while (n < nBits) begin
      @(posedge clk);
      #1;
      if (sampleStb) n++;
    end
    xferOn = 1'b0;
    while (busy) begin
      @(posedge clk);
      #1;
    end
    repeat (4) @(posedge clk);
    #1;
    check(expKind.size() == 0, {ctx, " R9"}, "events left over", expKind.size(), 0);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired R9 act=%0d exp=%0d", 150000, 0);
    finishRun();
  end

  initial begin
    int bad;
    int cnt100L, cnt100H, cnt400L, cnt400H;
    // R11 reset state
    repeat (3) @(posedge clk);
    #1;
    check(!sclDriveLow && !busy, "R11", "released and idle in reset", {sclDriveLow, busy}, 0);
    check(!(startStb | midLowStb | sampleStb | stopStb), "R11", "no strobe in reset",
          {startStb, midLowStb, sampleStb, stopStb}, 0);
    rstN = 1'b1;
    enable = 1'b1;
    repeat (10) @(posedge clk);
    #1;

    runXfer(1, 20, 12, 2'b00, 3, 3, 0, "base");
    runXfer(1, 20, 12, 2'b00, 2, 1, 15, "R2 stretched");
    runXfer(4, 5, 3, 2'b00, 2, 6, 0, "R5 divide-by-4");
    runXfer(0, 7, 5, 2'b00, 2, 2, 0, "R5 divider zero");
    runXfer(3, 0, 0, 2'b00, 2, 2, 0, "R4 zero counts");
    runXfer(1, 16, 4, 2'b10, 1, 2, 0, "R3 low bit8");
    runXfer(1, 6, 9, 2'b01, 1, 2, 3, "R3 high bit8");
    runXfer(1, 0, 0, 2'b11, 1, 2, 0, "R3 both bit8");

    cnt100L = ticksFor(25000, 47 + 3);
    cnt100H = ticksFor(25000, 40 + 3);
    cnt400L = ticksFor(25000, 13 + 3);
    cnt400H = ticksFor(25000, 6 + 3);
    check(cnt100L == 125 && cnt100H == 108, "R12", "standard counts", cnt100L * 1000 + cnt100H, 125108);
    check(cnt400L == 40 && cnt400H == 23, "R12", "fast counts", cnt400L * 1000 + cnt400H, 40023);
    runXfer(10, cnt100L, cnt100H, 2'b00, 1, 4, 0, "R12 standard");
    runXfer(10, cnt400L, cnt400H, 2'b00, 1, 4, 0, "R12 fast");

    // R10: disable in the middle of a low phase
    monOn = 1'b0;
    clkDiv = 8'd1;
    lowCount = 8'd30;
    highCount = 8'd20;
    countMsbs = 2'b00;
    xferOn = 1'b1;
    while (!sclDriveLow) begin
      @(posedge clk);
      #1;
    end
    enable = 1'b0;
    @(posedge clk);
    #1;
    check(!sclDriveLow && !busy, "R10", "release one cycle after disable", {sclDriveLow, busy}, 0);
    bad = 0;
    repeat (60) begin
      @(posedge clk);
      #1;
      if (sclDriveLow || busy || startStb) bad++;
    end
    check(bad == 0, "R10", "no activity while disabled", bad, 0);
    xferOn = 1'b0;
    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule